// File: doc/BRIEF.md
# Byte DMA Channel with Block Auto-Reload

This block is a single DMA channel that copies one byte per peripheral request. A firmware-programmed mode selects one of several request lines. On each served request the channel reads a byte from a source address and then writes that byte to a destination address over a memory port. The memory port has a ready handshake, so the memory can stall either phase. After each byte the source and destination pointers each hold, count up or count down on their own.

A 16-bit count register sets the block length. It decrements after every byte. The block ends when the count underflows: a byte is moved while the count is already zero, so a programmed value N gives N+1 bytes. At that point the channel raises a sticky flag and an optional interrupt. It also reloads the pointers and the count from shadow copies of the values firmware last wrote, so the next block repeats over the same memory unless firmware reprograms it.

Requests pass through a sample latch. The latch keeps a request that arrives while the channel is disabled or busy, and merges repeated requests into one. Firmware can clear the latch with the same register write that enables the channel.

Top module: `dma_reload_chan`

## Requirements
- R1: Each served request produces exactly one read at the source pointer followed by exactly one write at the destination pointer. The written byte equals the byte read.
- R2: The mode register at offset 0 sets the step applied after each byte. Bits 1:0 set the source step and bits 3:2 set the destination step. The encoding is 00 hold, 01 add one, 10 subtract one, and 11 hold.
- R3: The count (offsets 6 low, 7 high) decrements after each byte. A byte moved while the count is zero is the last of the block and sets the underflow flag, so a count of N moves N+1 bytes. The flag stays set until firmware clears it.
- R4: On underflow the source (offsets 2/3), destination (offsets 4/5) and count registers take back the values last written to them.
- R5: Bits 3:0 of the control register at offset 1 select the request line. A value k from 1 to 4 selects trig_req[k-1]. Value 0 and values above 4 select nothing.
- R6: A selected request is latched even while the channel is disabled or a byte is in flight. The latched request is served once the channel is enabled and idle. Several requests that arrive before service count as one.
- R7: In the control register, bit 7 enables the channel. Writing 1 to bit 6 clears the request latch in the same write, and bit 6 always reads 0. Writing C1 hex enables the channel, clears the latch and selects line 1.
- R8: Status register offset 8 has two bits. Bit 0 is the underflow flag: writing 0 to it clears it and writing 1 to it has no effect. Bit 1 is the interrupt enable. irq equals flag AND enable.
- R9: Writes to the pointer and count registers are ignored while a byte is in flight.
- R10: No transfer starts while bus_grant is low. While mem_ready is low, the active strobe, the address and the write data stay unchanged.
- R11: After reset all registers read 0, both strobes are low, and uf_flag and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational on cfg_addr) |
| trig_req | input | TRIG_N | Peripheral request lines |
| bus_grant | input | 1 | Memory port available for a new transfer |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_rd and mem_ready |
| mem_ready | input | 1 | Memory completes the current strobe |
| uf_flag | output | 1 | Sticky count-underflow flag |
| irq | output | 1 | Channel interrupt request |

## Verification
The data path is swept over all sixteen pairs of source and destination step codes. Each pair runs with a one-byte block and with a three-byte block that has memory wait states, so hold, increment and decrement are each told apart from the others by the addresses they write. The reserved code is told apart by showing it behaves as hold. The three-byte runs also show that the flag stays low until the last byte, and that the reload restores the written values rather than the stepped ones. Separate request patterns tell the latch behaviours apart: a request while disabled, a request followed by a latch-clearing enable, a double request merged into one, a request during a stalled transfer, a request on an unselected line, and a request while the grant is withheld.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
// Package: shared types and register offsets for the auto-reload DMA channel.
// Assumes byte-wide registers addressed by a 4-bit offset.
package dma_pkg;

    // Pointer step selection after each moved byte
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSV  = 2'b11
    } step_e;

    // Transfer sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10
    } xfer_st_e;

    localparam int SEL_W = 4;
    localparam int NPTR_BYTES = 6;

    localparam logic [3:0] OFS_STEP   = 4'd0;
    localparam logic [3:0] OFS_CTRL   = 4'd1;
    localparam logic [3:0] OFS_SRC_LO = 4'd2;
    localparam logic [3:0] OFS_SRC_HI = 4'd3;
    localparam logic [3:0] OFS_DST_LO = 4'd4;
    localparam logic [3:0] OFS_DST_HI = 4'd5;
    localparam logic [3:0] OFS_CNT_LO = 4'd6;
    localparam logic [3:0] OFS_CNT_HI = 4'd7;
    localparam logic [3:0] OFS_STAT   = 4'd8;

endpackage

// File: rtl/dma_ptr.sv
`timescale 1ns/1ps
// Module: one pointer/count register with a shadow copy.
// Byte writes update both the live value and the shadow copy. A step moves
// the live value by the selected amount, and a reload copies the shadow into
// the live value. Assumes the writer never writes in the same cycle as a step
// or a reload. W must lie in 9..16.
module dma_ptr
    import dma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wdata,
    input  logic         step_en,
    input  step_e        step_mode,
    input  logic         reload,
    output logic [W-1:0] live
);
    localparam int HW = W - 8;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] shadow;
    logic [W-1:0] stepped;

    // Next value for one step in the selected direction
    always_comb begin
        case (step_mode)
            STEP_INC: stepped = live + ONE;
            STEP_DEC: stepped = live - ONE;
            default:  stepped = live;
        endcase
    end

    // Live and shadow update: reload, then step, then byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            shadow <= '0;
        end else if (reload) begin
            live <= shadow;
        end else if (step_en) begin
            live <= stepped;
        end else begin
            if (wr_lo) begin
                live[7:0]   <= wdata;
                shadow[7:0] <= wdata;
            end
            if (wr_hi) begin
                live[W-1:8]   <= wdata[HW-1:0];
                shadow[W-1:8] <= wdata[HW-1:0];
            end
        end
    end

endmodule

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
// Module: register file for the channel.
// Holds the step modes, the enable, the request select, the interrupt enable
// and the sticky underflow flag. Decodes byte write strobes for the pointer
// registers and blocks them while a byte is in flight. Provides combinational
// readback. Assumes a write lasts one cycle.
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [3:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    input  logic                  busy,
    input  logic                  uf_evt,
    input  logic [AW-1:0]         src_live,
    input  logic [AW-1:0]         dst_live,
    input  logic [AW-1:0]         cnt_live,
    output step_e                 src_mode,
    output step_e                 dst_mode,
    output logic                  chan_en,
    output logic [SEL_W-1:0]      trig_sel,
    output logic                  latch_clr,
    output logic [NPTR_BYTES-1:0] ptr_wr,
    output logic                  uf_flag,
    output logic                  irq
);
    logic [3:0] step_q;
    logic       irq_en;
    logic       step_wr, ctrl_wr, stat_wr;

    assign step_wr   = cfg_wr && (cfg_addr == OFS_STEP);
    assign ctrl_wr   = cfg_wr && (cfg_addr == OFS_CTRL);
    assign stat_wr   = cfg_wr && (cfg_addr == OFS_STAT);
    assign latch_clr = ctrl_wr && cfg_wdata[6];
    assign src_mode  = step_e'(step_q[1:0]);
    assign dst_mode  = step_e'(step_q[3:2]);
    assign irq       = uf_flag && irq_en;

    // Byte write strobes for the six pointer bytes, blocked while busy
    for (genvar g = 0; g < NPTR_BYTES; g++) begin : g_ptr_wr
        localparam logic [3:0] OFS = OFS_SRC_LO + 4'(g);
        assign ptr_wr[g] = cfg_wr && !busy && (cfg_addr == OFS);
    end

    // Mode, control and interrupt-enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            chan_en  <= 1'b0;
            trig_sel <= '0;
            irq_en   <= 1'b0;
        end else begin
            if (step_wr) step_q <= cfg_wdata[3:0];
            if (ctrl_wr) begin
                chan_en  <= cfg_wdata[7];
                trig_sel <= cfg_wdata[SEL_W-1:0];
            end
            if (stat_wr) irq_en <= cfg_wdata[1];
        end
    end

    // Sticky underflow flag: set by the sequencer, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)                           uf_flag <= 1'b0;
        else if (uf_evt)                      uf_flag <= 1'b1;
        else if (stat_wr && !cfg_wdata[0])    uf_flag <= 1'b0;
    end

    // Readback multiplexer
    always_comb begin
        case (cfg_addr)
            OFS_STEP:   cfg_rdata = {4'b0, step_q};
            OFS_CTRL:   cfg_rdata = {chan_en, 3'b0, trig_sel};
            OFS_SRC_LO: cfg_rdata = src_live[7:0];
            OFS_SRC_HI: cfg_rdata = 8'(src_live >> 8);
            OFS_DST_LO: cfg_rdata = dst_live[7:0];
            OFS_DST_HI: cfg_rdata = 8'(dst_live >> 8);
            OFS_CNT_LO: cfg_rdata = cnt_live[7:0];
            OFS_CNT_HI: cfg_rdata = 8'(cnt_live >> 8);
            OFS_STAT:   cfg_rdata = {6'b0, irq_en, uf_flag};
            default:    cfg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/dma_trig_latch.sv
`timescale 1ns/1ps
// Module: request selection and sample latch.
// Picks one request line by the select code (k selects line k-1, 0 or out of
// range selects none). Sets the latch whenever that line is high, clears it
// when the sequencer takes a transfer, and lets a same-cycle request survive
// the take. A clear strobe empties the latch and drops any same-cycle request.
module dma_trig_latch
    import dma_pkg::*;
#(
    parameter int TRIG_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_N-1:0] trig_req,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              take,
    input  logic              clr,
    output logic              pending
);
    logic sel_req;

    // Request line multiplexer
    always_comb begin
        sel_req = 1'b0;
        for (int k = 0; k < TRIG_N; k++) begin
            if (trig_sel == SEL_W'(k + 1)) sel_req = trig_req[k];
        end
    end

    // Sample latch with take-clear and firmware clear
    always_ff @(posedge clk) begin
        if (!rst_n)   pending <= 1'b0;
        else if (clr) pending <= 1'b0;
        else          pending <= (pending && !take) || sel_req;
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
`timescale 1ns/1ps
// Module: byte transfer sequencer.
// From idle it starts when enabled, a request is latched and the grant is
// high. It then holds a read at the source until ready and captures the
// byte. Next it holds a write of that byte at the destination until ready,
// and pulses done. Assumes the pointers do not change while busy.
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          pending,
    input  logic          bus_grant,
    input  logic          mem_ready,
    input  logic [7:0]    mem_rdata,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          take,
    output logic          done,
    output logic          busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata
);
    xfer_st_e   state;
    logic [7:0] data_q;

    assign take = (state == ST_IDLE) && chan_en && pending && bus_grant;
    assign done = (state == ST_WR) && mem_ready;
    assign busy = (state != ST_IDLE);

    // Sequencer state and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) state <= ST_RD;
                ST_RD: if (mem_ready) begin
                    data_q <= mem_rdata;
                    state  <= ST_WR;
                end
                ST_WR: if (mem_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive from the current state
    always_comb begin
        mem_rd    = (state == ST_RD);
        mem_wr    = (state == ST_WR);
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == ST_RD) mem_addr = src_addr;
        if (state == ST_WR) begin
            mem_addr  = dst_addr;
            mem_wdata = data_q;
        end
    end

endmodule

// File: rtl/dma_reload_chan.sv
`timescale 1ns/1ps
// Module: top of the single byte DMA channel with auto-reload.
// Joins the register file, the request latch, the sequencer and three
// shadowed pointer registers. After each byte the pointers step and the count
// decrements. A byte moved at count zero is an underflow: it reloads all
// three registers from their shadows and sets the sticky flag.
module dma_reload_chan
    import dma_pkg::*;
#(
    parameter int AW     = 16,
    parameter int TRIG_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [TRIG_N-1:0] trig_req,
    input  logic              bus_grant,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              uf_flag,
    output logic              irq
);
    step_e                 src_mode, dst_mode;
    logic                  chan_en, latch_clr, pending;
    logic [SEL_W-1:0]      trig_sel;
    logic [NPTR_BYTES-1:0] ptr_wr;
    logic                  take, done, busy, uf_evt, step_en;
    logic [AW-1:0]         src_live, dst_live, cnt_live;

    assign uf_evt  = done && (cnt_live == '0);
    assign step_en = done && !uf_evt;

    dma_cfg_regs #(.AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .uf_evt(uf_evt), .src_live(src_live), .dst_live(dst_live),
        .cnt_live(cnt_live), .src_mode(src_mode), .dst_mode(dst_mode),
        .chan_en(chan_en), .trig_sel(trig_sel), .latch_clr(latch_clr),
        .ptr_wr(ptr_wr), .uf_flag(uf_flag), .irq(irq)
    );

    dma_trig_latch #(.TRIG_N(TRIG_N)) i_latch (
        .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .trig_sel(trig_sel),
        .take(take), .clr(latch_clr), .pending(pending)
    );

    dma_xfer_fsm #(.AW(AW)) i_fsm (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pending(pending),
        .bus_grant(bus_grant), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .src_addr(src_live), .dst_addr(dst_live), .take(take), .done(done),
        .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata)
    );

    dma_ptr #(.W(AW)) i_src (
        .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr[0]), .wr_hi(ptr_wr[1]),
        .wdata(cfg_wdata), .step_en(step_en), .step_mode(src_mode),
        .reload(uf_evt), .live(src_live)
    );

    dma_ptr #(.W(AW)) i_dst (
        .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr[2]), .wr_hi(ptr_wr[3]),
        .wdata(cfg_wdata), .step_en(step_en), .step_mode(dst_mode),
        .reload(uf_evt), .live(dst_live)
    );

    dma_ptr #(.W(AW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr[4]), .wr_hi(ptr_wr[5]),
        .wdata(cfg_wdata), .step_en(step_en), .step_mode(STEP_DEC),
        .reload(uf_evt), .live(cnt_live)
    );

endmodule

// File: rtl/dma_reload_chan_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the DMA channel, bound to the top module.
// Watches the memory port, the grant and the flag and interrupt outputs.
module dma_reload_chan_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flag_clr_wr,
    input logic          bus_grant,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [7:0]    mem_wdata,
    input logic [7:0]    mem_rdata,
    input logic          mem_ready,
    input logic          uf_flag,
    input logic          irq
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R1
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_rd && mem_ready)); // R1
    AST_WR_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> (mem_wdata == $past(mem_rdata))); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R10
    AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> $past(bus_grant)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !flag_clr_wr) |=> uf_flag); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> uf_flag); // R8
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .flag_clr_wr(cfg_wr && (cfg_addr == dma_pkg::OFS_STAT) && !cfg_wdata[0]),
    .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .uf_flag(uf_flag), .irq(irq)
);

// File: tb/test_dma_reload_chan.sv
`timescale 1ns/1ps
// Bench: sweeps step modes and block lengths, then exercises the request
// latch, grant, write blocking and status register. Expected memory contents
// are computed arithmetically from the step codes.
module test_dma_reload_chan;
    import dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  trig_req = '0;
    logic        bus_grant = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        uf_flag, irq;

    logic [7:0]  mem [65536];
    logic [7:0]  exp_mem [65536];
    int          wr_cnt = 0;
    int          errors = 0;
    int          checks = 0;
    logic        stall_en = 1'b0;
    logic        stall_force = 1'b0;
    logic [1:0]  stall_ctr = '0;

    always #2.5 clk = ~clk;

    dma_reload_chan i_dma_reload_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_req(trig_req),
        .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .uf_flag(uf_flag), .irq(irq)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    // Memory model: combinational read, clocked write with a write counter
    assign mem_rdata = mem[mem_addr];
    assign mem_ready = !stall_force && !(stall_en && (stall_ctr != 2'd0));
    always @(negedge clk) stall_ctr <= stall_ctr + 2'd1;
    always @(posedge clk) begin
        if (mem_wr && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        trig_req[k] = 1'b1;
        @(negedge clk);
        trig_req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_writes(input int target);
        int t = 0;
        while (wr_cnt < target && t < 500) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic set16(input logic [3:0] lo, input logic [15:0] v);
        wr_reg(lo, v[7:0]);
        wr_reg(lo + 4'd1, v[15:8]);
    endtask

    task automatic get16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd_reg(lo, l);
        rd_reg(lo + 4'd1, h);
        v = {h, l};
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  rv;
        logic [15:0] v16, cnt_before;
        int          base, mis;

        for (int a = 0; a < 65536; a++) begin
            mem[a] = pat(a);
            exp_mem[a] = pat(a);
        end
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R11: reset state of registers and outputs
        mis = 0;
        for (int a = 0; a < 9; a++) begin
            rd_reg(4'(a), rv);
            if (rv != 8'h00) mis++;
        end
        chk(mis == 0, "R11", "registers nonzero after reset", mis, 0);
        chk(!mem_rd && !mem_wr && !uf_flag && !irq, "R11", "outputs after reset",
            {mem_rd, mem_wr, uf_flag, irq}, 0);

        // R1 R2 R3 R4: sweep all step codes for one-byte and three-byte blocks
        for (int sm = 0; sm < 4; sm++) begin
            for (int dm = 0; dm < 4; dm++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int cnt = (ci == 1) ? 2 : 0;
                    int ds = (sm == 1) ? 1 : ((sm == 2) ? -1 : 0);
                    int dd = (dm == 1) ? 1 : ((dm == 2) ? -1 : 0);
                    stall_en = (ci == 1);
                    wr_reg(OFS_CTRL, 8'h01);
                    wr_reg(OFS_STEP, 8'((dm << 2) | sm));
                    set16(OFS_SRC_LO, 16'h1000);
                    set16(OFS_DST_LO, 16'h2000);
                    set16(OFS_CNT_LO, 16'(cnt));
                    wr_reg(OFS_STAT, 8'h00);
                    wr_reg(OFS_CTRL, 8'hC1);
                    for (int i = 0; i <= cnt; i++) begin
                        if (i == cnt)
                            chk(uf_flag == 1'b0, "R3", "flag before last byte", uf_flag, 0);
                        base = wr_cnt;
                        pulse(0);
                        wait_writes(base + 1);
                        exp_mem[16'(32'h2000 + i * dd)] = exp_mem[16'(32'h1000 + i * ds)];
                    end
                    idle(3);
                    chk(uf_flag == 1'b1, "R3", "flag after last byte", uf_flag, 1);
                    mis = 0;
                    for (int a = 16'h0FF0; a < 16'h1010; a++)
                        if (mem[a] != exp_mem[a]) mis++;
                    for (int a = 16'h1FF0; a < 16'h2010; a++)
                        if (mem[a] != exp_mem[a]) mis++;
                    chk(mis == 0, "R1 R2", $sformatf("memory window sm=%0d dm=%0d", sm, dm), mis, 0);
                    get16(OFS_SRC_LO, v16);
                    chk(v16 == 16'h1000, "R4", "source reload", v16, 16'h1000);
                    get16(OFS_DST_LO, v16);
                    chk(v16 == 16'h2000, "R4", "destination reload", v16, 16'h2000);
                    get16(OFS_CNT_LO, v16);
                    chk(v16 == 16'(cnt), "R4", "count reload", v16, cnt);
                end
            end
        end
        stall_en = 1'b0;

        // R8: status flag clear rules and interrupt gating (flag is set here)
        chk(irq == 1'b0, "R8", "irq with enable low", irq, 0);
        wr_reg(OFS_STAT, 8'h03);
        idle(1);
        chk(uf_flag == 1'b1 && irq == 1'b1, "R8", "write one keeps flag, irq on",
            {uf_flag, irq}, 2'b11);
        wr_reg(OFS_STAT, 8'h02);
        rd_reg(OFS_STAT, rv);
        chk(rv == 8'h02 && !irq, "R8", "write zero clears flag", rv, 8'h02);

        // Common setup for latch tests: both pointers held, long count
        wr_reg(OFS_CTRL, 8'h01);
        wr_reg(OFS_STEP, 8'h00);
        set16(OFS_SRC_LO, 16'h1000);
        set16(OFS_DST_LO, 16'h3000);
        set16(OFS_CNT_LO, 16'h0100);

        // R6: request captured while disabled, served after enable
        base = wr_cnt;
        pulse(0);
        idle(10);
        chk(wr_cnt == base, "R6", "no transfer while disabled", wr_cnt - base, 0);
        wr_reg(OFS_CTRL, 8'h81);
        wait_writes(base + 1);
        idle(10);
        chk(wr_cnt == base + 1, "R6", "latched request served", wr_cnt - base, 1);

        // R7: enable with latch clear drops the stored request
        wr_reg(OFS_CTRL, 8'h01);
        base = wr_cnt;
        pulse(0);
        wr_reg(OFS_CTRL, 8'hC1);
        idle(10);
        chk(wr_cnt == base, "R7", "cleared latch gives no transfer", wr_cnt - base, 0);
        rd_reg(OFS_CTRL, rv);
        chk(rv == 8'h81, "R7", "control readback, clear bit reads 0", rv, 8'h81);

        // R6: two requests before service merge into one transfer
        wr_reg(OFS_CTRL, 8'h01);
        base = wr_cnt;
        pulse(0);
        pulse(0);
        wr_reg(OFS_CTRL, 8'h81);
        idle(15);
        chk(wr_cnt == base + 1, "R6", "merged requests", wr_cnt - base, 1);

        // R6 R9 R3: request during a stalled transfer is kept; writes blocked
        get16(OFS_CNT_LO, cnt_before);
        stall_force = 1'b1;
        base = wr_cnt;
        pulse(0);
        for (int t = 0; t < 50 && !mem_rd; t++) @(negedge clk);
        pulse(0);
        wr_reg(OFS_SRC_LO, 8'h55);
        stall_force = 1'b0;
        wait_writes(base + 2);
        idle(10);
        chk(wr_cnt == base + 2, "R6", "request held during transfer", wr_cnt - base, 2);
        rd_reg(OFS_SRC_LO, rv);
        chk(rv == 8'h00, "R9", "source write ignored while busy", rv, 8'h00);
        get16(OFS_CNT_LO, v16);
        chk(v16 == cnt_before - 16'd2, "R3", "count decrement per byte", v16, cnt_before - 16'd2);

        // R10: no start without grant
        bus_grant = 1'b0;
        base = wr_cnt;
        pulse(0);
        idle(10);
        chk(wr_cnt == base && !mem_rd, "R10", "no transfer without grant", wr_cnt - base, 0);
        bus_grant = 1'b1;
        wait_writes(base + 1);
        idle(5);
        chk(wr_cnt == base + 1, "R10", "transfer after grant", wr_cnt - base, 1);

        // R5: request line selection
        wr_reg(OFS_CTRL, 8'hC2);
        base = wr_cnt;
        pulse(0);
        idle(10);
        chk(wr_cnt == base, "R5", "unselected line ignored", wr_cnt - base, 0);
        pulse(1);
        wait_writes(base + 1);
        idle(5);
        chk(wr_cnt == base + 1, "R5", "selected line 2 served", wr_cnt - base, 1);
        wr_reg(OFS_CTRL, 8'hC0);
        base = wr_cnt;
        for (int k = 0; k < 4; k++) pulse(k);
        idle(10);
        chk(wr_cnt == base, "R5", "select 0 serves nothing", wr_cnt - base, 0);
        wr_reg(OFS_CTRL, 8'hC7);
        for (int k = 0; k < 4; k++) pulse(k);
        idle(10);
        chk(wr_cnt == base, "R5", "select above range serves nothing", wr_cnt - base, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule